// File: doc/BRIEF.md
# Multicycle Floating-Point Issue Interlock

This block is the decode-stage issue gate of an in-order pipeline whose execute phase offers four functional units of unequal length. These are a single-cycle integer unit, a pipelined FP adder, a pipelined FP multiplier and an unpipelined FP divider. Each cycle the decoder presents one instruction. The instruction carries a valid flag, its unit class, two source register numbers, a destination register number and a flag that says whether it writes a register at all. The block answers in the same cycle with either `issue` or `stall`.

Three pieces of state decide the answer. The first is a per-register countdown of results still in flight. The second is a countdown of divider occupancy. The third is a shift register of future cycles in which the single register-file write port is already promised. A stalled instruction stays at decode. It issues in the first cycle in which every hazard has cleared. Forwarding paths, the unit datapaths and exception recovery belong to other blocks.

Top module: `fp_issue_interlock`

## Requirements
- R1: With `decValid` low, `issue` and `stall` are both 0.
- R2: Unit class encoding is 0 integer, 1 add, 2 multiply and 3 divide. An integer result never causes a stall: a consumer or an overwriter of its destination may issue in the very next cycle.
- R3: The divider is unpipelined. A divide issued in cycle t blocks every other divide until cycle t+24, in which a divide may issue.
- R4: Read-after-write: a reader of the destination of an add, multiply or divide issued in cycle t stalls until cycle t+4, t+7 or t+24 respectively. The result latency is one less than the execute depth.
- R5: Write-after-write: an instruction with a destination stalls while an add, multiply or divide with the same destination is still in its execute stages. For a producer of depth d issued in cycle t, the instruction issues at t+d+1.
- R6: Write-port booking: an instruction issued in cycle t writes the register file in cycle t+d, with d equal to 1, 4, 7 or 24 for integer, add, multiply or divide. An instruction with a destination stalls while its write cycle is already booked.
- R7: An instruction whose `decHasDst` is 0 books no write-port cycle, records no pending destination, and is checked neither for write-port conflicts nor for write-after-write.
- R8: Independent adds, and likewise independent multiplies, issue back to back, one per cycle.
- R9: A synchronous reset clears every pending destination, every write-port booking and the divider countdown. The first valid instruction after reset issues at once.
- R10: With `decValid` high, exactly one of `issue` and `stall` is 1. A held instruction issues in the first cycle in which no hazard remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| decValid | input | 1 | Decode slot holds an instruction |
| decUnit | input | 2 | Unit class: 0 int, 1 add, 2 mul, 3 div |
| decSrcA | input | REG_W | First source register |
| decSrcB | input | REG_W | Second source register |
| decDst | input | REG_W | Destination register |
| decHasDst | input | 1 | Instruction writes a register |
| issue | output | 1 | Instruction leaves decode this cycle |
| stall | output | 1 | Instruction is held at decode |

## Verification
The write-port booking and the register hazards (read-after-write and write-after-write) can demand a stall in the same cycle. The divider countdown can overlap both as well. The bench provokes this overlap with a producer of each unit followed by a consumer of each unit. It sweeps the cycle in which the consumer first appears, so that the consumer's write slot lands exactly on the producer's while a register dependency is still open. The expected issue cycle is computed as the first cycle that meets every constraint at once. The bench compares it with the cycle in which `issue` rises, and it requires `stall` in every waiting cycle before that.

// File: rtl/issue_pkg.sv
package issue_pkg;

  typedef enum logic [1:0] {
    UNIT_INT = 2'd0,
    UNIT_ADD = 2'd1,
    UNIT_MUL = 2'd2,
    UNIT_DIV = 2'd3
  } unit_e;

  // strobes from control to the tracking datapath
  typedef struct packed {
    logic issueStb;
    logic claimDst;
  } ctl_s;

  // raw hazard indications from the datapath
  typedef struct packed {
    logic rawHit;
    logic wawHit;
    logic portHit;
    logic divBusy;
  } haz_s;

endpackage

// File: rtl/issue_track_dp.sv
module issue_track_dp
  import issue_pkg::*;
#(
  parameter int REG_W      = 5,
  parameter int ADD_DEPTH  = 4,
  parameter int MUL_DEPTH  = 7,
  parameter int DIV_CYCLES = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [REG_W-1:0] decSrcA,
  input  logic [REG_W-1:0] decSrcB,
  input  logic [REG_W-1:0] decDst,
  input  unit_e            decUnit,
  input  ctl_s             ctl,
  output haz_s             haz
);
  localparam int NUM_REGS = 1 << REG_W;
  localparam int SLOT_N   = DIV_CYCLES;
  localparam int CNT_W    = $clog2(DIV_CYCLES + 1);

  logic [CNT_W-1:0]  regCnt [NUM_REGS];
  logic [SLOT_N-1:0] slots;
  logic [SLOT_N-1:0] slotsNext;
  logic [CNT_W-1:0]  divCnt;
  logic [CNT_W-1:0]  depth;
  logic [CNT_W-1:0]  checkIdx;
  logic [CNT_W-1:0]  bookIdx;
  logic              isFp;

  always_comb begin
    unique case (decUnit)
      UNIT_INT: depth = CNT_W'(1);
      UNIT_ADD: depth = CNT_W'(ADD_DEPTH);
      UNIT_MUL: depth = CNT_W'(MUL_DEPTH);
      default:  depth = CNT_W'(DIV_CYCLES);
    endcase
  end

  assign isFp     = (decUnit != UNIT_INT);
  assign checkIdx = depth - CNT_W'(1);
  assign bookIdx  = depth - CNT_W'(2);

  // hazard views of the tracked state (R4, R5, R6, R3)
  always_comb begin
    haz.rawHit  = (regCnt[decSrcA] > CNT_W'(1)) || (regCnt[decSrcB] > CNT_W'(1));
    haz.wawHit  = (regCnt[decDst] != '0);
    haz.portHit = slots[checkIdx];
    haz.divBusy = (divCnt != '0);
  end

  // per-register in-flight countdown; integer results never linger (R2)
  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : gRegCnt
      always_ff @(posedge clk) begin
        if (rst)
          regCnt[g] <= '0;
        else if (ctl.claimDst && isFp && (decDst == REG_W'(g)))
          regCnt[g] <= depth;
        else if (regCnt[g] != '0)
          regCnt[g] <= regCnt[g] - CNT_W'(1);
      end
    end
  endgenerate

  // write-port booking shift register: bit j = port used j+1 cycles ahead (R6)
  always_comb begin
    slotsNext = {1'b0, slots[SLOT_N-1:1]};
    if (ctl.claimDst && isFp)
      slotsNext[bookIdx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) slots <= '0;
    else     slots <= slotsNext;
  end

  // divider occupancy (R3)
  always_ff @(posedge clk) begin
    if (rst)
      divCnt <= '0;
    else if (ctl.issueStb && decUnit == UNIT_DIV)
      divCnt <= CNT_W'(DIV_CYCLES - 1);
    else if (divCnt != '0)
      divCnt <= divCnt - CNT_W'(1);
  end

endmodule

// File: rtl/issue_ctrl.sv
module issue_ctrl
  import issue_pkg::*;
(
  input  logic  decValid,
  input  unit_e decUnit,
  input  logic  decHasDst,
  input  haz_s  haz,
  output logic  stall,
  output logic  issue,
  output ctl_s  ctl
);
  logic waitAny;

  // destination-free instructions skip port and WAW checks (R7)
  assign waitAny = haz.rawHit
                 | (decHasDst & haz.wawHit)
                 | (decHasDst & haz.portHit)
                 | ((decUnit == UNIT_DIV) & haz.divBusy);

  assign stall        = decValid & waitAny;   // R10
  assign issue        = decValid & ~waitAny;
  assign ctl.issueStb = issue;
  assign ctl.claimDst = issue & decHasDst;

endmodule

// File: rtl/fp_issue_interlock.sv
module fp_issue_interlock
  import issue_pkg::*;
#(
  parameter int REG_W      = 5,
  parameter int ADD_DEPTH  = 4,
  parameter int MUL_DEPTH  = 7,
  parameter int DIV_CYCLES = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             decValid,
  input  logic [1:0]       decUnit,
  input  logic [REG_W-1:0] decSrcA,
  input  logic [REG_W-1:0] decSrcB,
  input  logic [REG_W-1:0] decDst,
  input  logic             decHasDst,
  output logic             issue,
  output logic             stall
);
  unit_e unitCls;
  ctl_s  ctl;
  haz_s  haz;

  assign unitCls = unit_e'(decUnit);

  issue_track_dp #(
    .REG_W(REG_W), .ADD_DEPTH(ADD_DEPTH),
    .MUL_DEPTH(MUL_DEPTH), .DIV_CYCLES(DIV_CYCLES)
  ) uDp (
    .clk(clk), .rst(rst),
    .decSrcA(decSrcA), .decSrcB(decSrcB), .decDst(decDst),
    .decUnit(unitCls), .ctl(ctl), .haz(haz)
  );

  issue_ctrl uCtrl (
    .decValid(decValid), .decUnit(unitCls), .decHasDst(decHasDst),
    .haz(haz), .stall(stall), .issue(issue), .ctl(ctl)
  );

endmodule

// File: rtl/issue_interlock_chk.sv
module issue_interlock_chk #(
  parameter int DIV_CYCLES = 24
) (
  input logic       clk,
  input logic       rst,
  input logic       decValid,
  input logic [1:0] decUnit,
  input logic       issue,
  input logic       stall
);
  int sinceDiv;

  always_ff @(posedge clk) begin
    if (rst)
      sinceDiv <= DIV_CYCLES;
    else if (issue && decUnit == 2'd3)
      sinceDiv <= 1;
    else if (sinceDiv < DIV_CYCLES)
      sinceDiv <= sinceDiv + 1;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !decValid |-> (!issue && !stall)); // R1

  AST_ONE_DECISION: assert property (@(posedge clk) disable iff (rst)
    decValid |-> (issue != stall)); // R10

  AST_DIV_GAP: assert property (@(posedge clk) disable iff (rst)
    (issue && decUnit == 2'd3) |-> (sinceDiv >= DIV_CYCLES)); // R3

  AST_CLEAN_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && decValid) |-> issue); // R9

endmodule

bind fp_issue_interlock issue_interlock_chk #(.DIV_CYCLES(DIV_CYCLES)) uChk (
  .clk(clk), .rst(rst), .decValid(decValid), .decUnit(decUnit),
  .issue(issue), .stall(stall)
);

// File: tb/tb_fp_issue_interlock.sv
module tb_fp_issue_interlock;
  localparam int ADD_D = 4;
  localparam int MUL_D = 7;
  localparam int DIV_D = 24;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       decValid = 1'b0;
  logic [1:0] decUnit = 2'd0;
  logic [4:0] decSrcA = '0, decSrcB = '0, decDst = '0;
  logic       decHasDst = 1'b0;
  logic       issue, stall;
  int passCnt = 0;
  int failCnt = 0;

  fp_issue_interlock dut (
    .clk(clk), .rst(rst), .decValid(decValid), .decUnit(decUnit),
    .decSrcA(decSrcA), .decSrcB(decSrcB), .decDst(decDst),
    .decHasDst(decHasDst), .issue(issue), .stall(stall)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    if (ok) passCnt++;
    else begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int depthOf(input int u);
    case (u)
      0: return 1;
      1: return ADD_D;
      2: return MUL_D;
      default: return DIV_D;
    endcase
  endfunction

  // earliest legal issue cycle of a consumer, producer issued at cycle 0
  function automatic int expIssue(input int p, input int c, input int rel, input int s);
    int dp = depthOf(p);
    int dc = depthOf(c);
    bit hasDst = (rel != 3);
    for (int k = s; k < s + 100; k++) begin
      bit ok = 1;
      if (rel == 1 && p != 0 && k < dp) ok = 0;             // RAW
      if (rel == 2 && p != 0 && k < dp + 1) ok = 0;         // WAW
      if (p == 3 && c == 3 && k < DIV_D) ok = 0;            // divider
      if (hasDst && p != 0 && k + dc == dp) ok = 0;         // write port
      if (ok) return k;
    end
    return -1;
  endfunction

  task automatic drive(input bit v, input int u, input int a, input int b,
                       input int d, input bit hd);
    decValid  = v;
    decUnit   = 2'(u);
    decSrcA   = 5'(a);
    decSrcB   = 5'(b);
    decDst    = 5'(d);
    decHasDst = hd;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    drive(0, 0, 0, 0, 0, 0);
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic runCase(input int p, input int c, input int rel, input int s);
    int got = -1;
    bit waitOk = 1;
    int exp;
    string tag;
    doReset();
    drive(1, p, 1, 2, 5, 1);
    #1;
    check(issue == 1'b1, "R9", issue, 1);
    @(negedge clk);
    for (int k = 1; k < 120; k++) begin
      if (k >= s) begin
        case (rel)
          0: drive(1, c, 10, 11, 9, 1);
          1: drive(1, c, 5, 11, 9, 1);
          2: drive(1, c, 10, 11, 5, 1);
          default: drive(1, c, 10, 11, 5, 0);
        endcase
      end else drive(0, 0, 0, 0, 0, 0);
      #1;
      if (k >= s) begin
        if (issue) begin got = k; break; end
        if (!stall) waitOk = 0;
      end else if (issue || stall) waitOk = 0;
      @(negedge clk);
    end
    @(negedge clk);
    drive(0, 0, 0, 0, 0, 0);
    exp = expIssue(p, c, rel, s);
    if (p == 3 && c == 3) tag = "R3";
    else if (p == 0) tag = "R2";
    else if (rel == 1) tag = "R4";
    else if (rel == 2) tag = "R5";
    else if (rel == 0) tag = "R6";
    else tag = "R7";
    check(got == exp, tag, got, exp);
    check(waitOk, "R10", int'(waitOk), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL R10 watchdog actual=%0d expected=%0d", 0, 1);
    $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
    $finish;
  end

  initial begin
    doReset();
    #1;
    check(issue == 1'b0 && stall == 1'b0, "R1", int'({issue, stall}), 0);

    // R8: back-to-back independent adds, then multiplies
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      drive(1, 1, 20, 21, 1 + i, 1);
      #1;
      check(issue == 1'b1, "R8", issue, 1);
      @(negedge clk);
    end
    for (int i = 0; i < 8; i++) begin
      drive(1, 2, 20, 21, 12 + i, 1);
      #1;
      check(issue == 1'b1, "R8", issue, 1);
      @(negedge clk);
    end
    drive(0, 0, 0, 0, 0, 0);

    // R7: destination-free multiply books nothing; add aimed at its slot issues
    doReset();
    drive(1, 2, 1, 2, 5, 0);
    @(negedge clk);
    drive(0, 0, 0, 0, 0, 0);
    @(negedge clk);
    @(negedge clk);
    drive(1, 1, 10, 11, 5, 1);
    #1;
    check(issue == 1'b1, "R7", issue, 1);
    @(negedge clk);
    drive(0, 0, 0, 0, 0, 0);

    // sweep producer x consumer x relation x presentation delay
    for (int p = 0; p < 4; p++)
      for (int c = 0; c < 4; c++)
        for (int rel = 0; rel < 4; rel++)
          for (int s = 1; s <= 6; s++)
            runCase(p, c, rel, s);

    $display("%0d/%0d checks passed", passCnt, passCnt + failCnt);
    $finish;
  end

endmodule